// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory. A kick starts a walk at the current descriptor pointer. Each ready descriptor is fetched, its buffer bytes are read from memory, and those bytes are appended to the frame under construction. The frame leaves on a byte stream with start and end markers. A descriptor flagged as last closes the frame. Every consumed descriptor is then written back with its ready bit cleared, and event pulses report buffers, frames and oversize truncation.

Memory is reached through a word-addressed master. A request channel with valid/ready carries a word address, a write flag and write data. One read is outstanding at a time, and its data returns on a response strobe that the block always accepts. The byte stream is valid/ready. Once `out_valid` is high, the byte and both markers stay unchanged until `out_ready` takes them, so the consumer may hold `out_ready` low for as long as it needs. A request follows the same rule: address, write flag and data stay fixed until `mem_req_ready` is seen. The last byte read is held inside the block until it is known whether that byte ends the frame, so the stream moves one byte behind the memory reads.

The ring base may be written only while `busy` is low.

Top module: `txdesc_ring_walker`

## Requirements
- R1: A descriptor is two big-endian memory words. Word 0 holds the flags in bits 31:16 and the buffer length in bytes in bits 15:0. Word 1 holds the buffer byte address. Within the flags, bit 15 means ready, bit 13 means wrap and bit 11 means last buffer of the frame.
- R2: A kick starts a walk only if `enable` is high in the same cycle. A kick with `enable` low has no effect: `busy` stays low, no memory request is made and no descriptor changes.
- R3: A walk ends at the first descriptor whose ready bit is clear. That descriptor is not written. The current pointer stays on it, so the next kick resumes there.
- R4: One walk consumes at most MAX_DESC descriptors (default 1024). The pointer is then left on the next descriptor.
- R5: After a descriptor is consumed, the pointer moves to the ring base if that descriptor's wrap bit is set, and to its own address plus 8 otherwise.
- R6: The bytes of consecutive consumed descriptors form one frame, kept in order, from any byte alignment. The byte at the lowest address sits in bits 31:24 of a memory word. `out_sof` marks the first byte of a frame and `out_eof` marks the final byte of the descriptor flagged last. A zero-length buffer adds nothing, and a frame with no bytes produces no stream beat.
- R7: A frame holds at most MAX_FRAME bytes (default 2032). A buffer that would exceed this limit gives only the bytes that fit, and `ev_tx_babble` pulses together with its `ev_tx_buf`.
- R8: Write-back stores word 0 with only bit 31 (the ready flag) cleared. The other flag bits and the length are kept. Word 1 is never written.
- R9: Each consumed descriptor gives a one-cycle `ev_tx_buf` pulse when it is written back. A descriptor flagged last also pulses `ev_tx_frame` in the same cycle.
- R10: Writing the base forces its two low bits to zero and sets the current pointer to that base.
- R11: A kick that arrives with `enable` high during a walk is remembered. A new walk starts from the current pointer as soon as the running one ends.
- R12: While `out_valid` is high and `out_ready` is low, the byte and markers hold. While `mem_req_valid` is high and `mem_req_ready` is low, the request holds.
- R13: After reset `busy`, `out_valid`, `mem_req_valid` and all event outputs are low, and the base and pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable level |
| kick | input | 1 | Start-walk pulse |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | ADDR_W | New ring base byte address |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_waddr | output | ADDR_W-2 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Consumer takes byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Final byte of frame |
| ev_tx_buf | output | 1 | Descriptor consumed pulse |
| ev_tx_frame | output | 1 | Frame completed pulse |
| ev_tx_babble | output | 1 | Truncation pulse |

## Verification
Single-buffer frames are swept over every byte alignment of the buffer pointer and over every length from 0 to 9. This separates lane selection, the word-boundary refetch and the empty-frame case. Chained buffers with a zero-length middle and a wrapping tail show that gathering and the return to the base are right. A frame that passes a small frame limit tells clipped bytes apart from dropped ones. Rings longer than a small walk cap, with a single kick and with a kick repeated during the walk, tell the cap, resume and latched-kick behaviours apart. Random back-pressure on the memory and on the stream stays active throughout.

// File: rtl/txw_pkg.sv
package txw_pkg;
  // walk controller states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RQ_HEAD,
    ST_WT_HEAD,
    ST_RQ_PTR,
    ST_WT_PTR,
    ST_RQ_DATA,
    ST_WT_DATA,
    ST_EMIT,
    ST_FLUSH,
    ST_WBACK
  } walk_st_t;

  // flag bit positions inside the 16-bit descriptor flags
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/txw_byte_stager.sv
// Holds one byte back so the frame end marker can be attached to it.
module txw_byte_stager (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       flush_req,
  output logic       flush_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  logic       hold_v;
  logic [7:0] hold_d;
  logic       hold_sof;
  logic       sof_next;
  logic       slot_free;

  assign slot_free  = !out_valid || out_ready;
  assign in_ready   = !hold_v || slot_free;
  assign flush_done = !hold_v || slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_sof  <= 1'b0;
      sof_next  <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_valid && in_ready) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_d;
          out_sof   <= hold_sof;
          out_eof   <= 1'b0;
        end
        hold_v   <= 1'b1;
        hold_d   <= in_data;
        hold_sof <= sof_next;
        sof_next <= 1'b0;
      end else if (flush_req && hold_v && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= hold_d;
        out_sof   <= hold_sof;
        out_eof   <= 1'b1;
        hold_v    <= 1'b0;
        sof_next  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txw_walk_core.sv
// Descriptor fetch, buffer read, write-back and ring pointer control.
module txw_walk_core
  import txw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-3:0] mem_req_waddr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  input  logic              byte_ready,
  output logic              flush_req,
  input  logic              flush_done,
  output logic              ev_tx_buf,
  output logic              ev_tx_frame,
  output logic              ev_tx_babble
);
  localparam int FCW = $clog2(MAX_FRAME + 1);
  localparam int DCW = $clog2(MAX_DESC + 1);

  walk_st_t          st;
  logic [ADDR_W-1:0] base_q, cur_q, baddr_q;
  logic [15:0]       flags_q, len_q, rem_q;
  logic              clip_q, pend_q;
  logic [FCW-1:0]    fcnt_q;
  logic [DCW-1:0]    dcnt_q;
  logic [31:0]       wbuf_q;
  logic              kick_ok;
  logic [15:0]       flags_wb;
  logic [FCW-1:0]    room;
  logic [31:0]       room_w, len_w;
  logic              clip_c;
  logic [15:0]       take_c;
  logic [1:0]        lane;
  logic              last_f;

  assign kick_ok = kick && enable;
  assign busy    = (st != ST_IDLE);
  assign last_f  = flags_q[FLAG_LAST];

  // size clipping against the frame limit
  assign room   = FCW'(MAX_FRAME) - fcnt_q;
  assign room_w = 32'(room);
  assign len_w  = {16'd0, mem_rsp_rdata[15:0]};
  assign clip_c = len_w > room_w;
  assign take_c = clip_c ? room_w[15:0] : mem_rsp_rdata[15:0];

  always_comb begin
    flags_wb = flags_q;
    flags_wb[FLAG_READY] = 1'b0;
  end

  always_comb begin
    mem_req_valid = (st == ST_RQ_HEAD) || (st == ST_RQ_PTR) ||
                    (st == ST_RQ_DATA) || (st == ST_WBACK);
    mem_req_write = (st == ST_WBACK);
    mem_req_wdata = {flags_wb, len_q};
    case (st)
      ST_RQ_PTR:  mem_req_waddr = cur_q[ADDR_W-1:2] + 1'b1;
      ST_RQ_DATA: mem_req_waddr = baddr_q[ADDR_W-1:2];
      default:    mem_req_waddr = cur_q[ADDR_W-1:2];
    endcase
  end

  // big-endian lane pick: address offset 0 is bits 31:24
  assign lane       = 2'd3 - baddr_q[1:0];
  assign byte_data  = wbuf_q[{lane, 3'b000} +: 8];
  assign byte_valid = (st == ST_EMIT);
  assign flush_req  = (st == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      base_q       <= '0;
      cur_q        <= '0;
      baddr_q      <= '0;
      flags_q      <= '0;
      len_q        <= '0;
      rem_q        <= '0;
      clip_q       <= 1'b0;
      pend_q       <= 1'b0;
      fcnt_q       <= '0;
      dcnt_q       <= '0;
      wbuf_q       <= '0;
      ev_tx_buf    <= 1'b0;
      ev_tx_frame  <= 1'b0;
      ev_tx_babble <= 1'b0;
    end else begin
      ev_tx_buf    <= 1'b0;
      ev_tx_frame  <= 1'b0;
      ev_tx_babble <= 1'b0;
      if (kick_ok && st != ST_IDLE) pend_q <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (kick_ok) begin
            st     <= ST_RQ_HEAD;
            dcnt_q <= '0;
          end
        end
        ST_RQ_HEAD: if (mem_req_ready) st <= ST_WT_HEAD;
        ST_WT_HEAD: begin
          if (mem_rsp_valid) begin
            flags_q <= mem_rsp_rdata[31:16];
            len_q   <= mem_rsp_rdata[15:0];
            if (!mem_rsp_rdata[16+FLAG_READY]) begin
              if (pend_q || kick_ok) begin
                st     <= ST_RQ_HEAD;
                dcnt_q <= '0;
                pend_q <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              rem_q  <= take_c;
              clip_q <= clip_c;
              fcnt_q <= fcnt_q + FCW'(take_c);
              st     <= ST_RQ_PTR;
            end
          end
        end
        ST_RQ_PTR: if (mem_req_ready) st <= ST_WT_PTR;
        ST_WT_PTR: begin
          if (mem_rsp_valid) begin
            baddr_q <= mem_rsp_rdata[ADDR_W-1:0];
            if (rem_q == 16'd0) st <= last_f ? ST_FLUSH : ST_WBACK;
            else                st <= ST_RQ_DATA;
          end
        end
        ST_RQ_DATA: if (mem_req_ready) st <= ST_WT_DATA;
        ST_WT_DATA: begin
          if (mem_rsp_valid) begin
            wbuf_q <= mem_rsp_rdata;
            st     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (byte_ready) begin
            baddr_q <= baddr_q + 1'b1;
            rem_q   <= rem_q - 16'd1;
            if (rem_q == 16'd1)             st <= last_f ? ST_FLUSH : ST_WBACK;
            else if (baddr_q[1:0] == 2'b11) st <= ST_RQ_DATA;
          end
        end
        ST_FLUSH: begin
          if (flush_done) begin
            fcnt_q <= '0;
            st     <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          if (mem_req_ready) begin
            ev_tx_buf    <= 1'b1;
            ev_tx_frame  <= last_f;
            ev_tx_babble <= clip_q;
            cur_q <= flags_q[FLAG_WRAP] ? base_q : cur_q + ADDR_W'(DESC_BYTES);
            if (dcnt_q == DCW'(MAX_DESC - 1)) begin
              if (pend_q || kick_ok) begin
                st     <= ST_RQ_HEAD;
                dcnt_q <= '0;
                pend_q <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
              st     <= ST_RQ_HEAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (base_wr) begin
        base_q <= base_wdata & ~ADDR_W'(3);
        cur_q  <= base_wdata & ~ADDR_W'(3);
      end
    end
  end
endmodule

// File: rtl/txdesc_ring_walker.sv
module txdesc_ring_walker #(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-3:0] mem_req_waddr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              ev_tx_buf,
  output logic              ev_tx_frame,
  output logic              ev_tx_babble
);
  logic       byte_valid, byte_ready;
  logic [7:0] byte_data;
  logic       flush_req, flush_done;

  txw_walk_core #(
    .ADDR_W   (ADDR_W),
    .MAX_FRAME(MAX_FRAME),
    .MAX_DESC (MAX_DESC)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .kick         (kick),
    .base_wr      (base_wr),
    .base_wdata   (base_wdata),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_waddr(mem_req_waddr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_ready   (byte_ready),
    .flush_req    (flush_req),
    .flush_done   (flush_done),
    .ev_tx_buf    (ev_tx_buf),
    .ev_tx_frame  (ev_tx_frame),
    .ev_tx_babble (ev_tx_babble)
  );

  txw_byte_stager u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (byte_valid),
    .in_data   (byte_data),
    .in_ready  (byte_ready),
    .flush_req (flush_req),
    .flush_done(flush_done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );
endmodule

// File: rtl/txdesc_ring_walker_chk.sv
module txdesc_ring_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              kick,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-3:0] mem_req_waddr,
  input logic [31:0]       mem_req_wdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_sof,
  input logic              out_eof,
  input logic              ev_tx_buf,
  input logic              ev_tx_frame,
  input logic              ev_tx_babble
);
  a_r12_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_sof) && $stable(out_eof));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write) &&
                                        $stable(mem_req_waddr) && $stable(mem_req_wdata));

  a_r8_wb_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> !mem_req_wdata[31]);

  a_r9_frame_has_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_frame |-> ev_tx_buf);

  a_r7_babble_has_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_babble |-> ev_tx_buf);

  a_r2_disabled_kick: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && kick && !enable |=> !busy);

  a_r13_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
endmodule

bind txdesc_ring_walker txdesc_ring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txdesc_ring_walker_bench.sv
module txdesc_ring_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int MAXF = 40;
  localparam int MAXD = 6;
  localparam logic [15:0] F_RDY  = 16'h8000;
  localparam logic [15:0] F_WRAP = 16'h2000;
  localparam logic [15:0] F_LAST = 16'h0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, kick = 1'b0, base_wr = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic busy;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-3:0] mem_req_waddr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic out_valid, out_ready, out_sof, out_eof;
  logic [7:0] out_data;
  logic ev_tx_buf, ev_tx_frame, ev_tx_babble;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_ring_walker #(.ADDR_W(AW), .MAX_FRAME(MAXF), .MAX_DESC(MAXD)) u_txdesc_ring_walker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
    .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_waddr(mem_req_waddr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .ev_tx_buf(ev_tx_buf), .ev_tx_frame(ev_tx_frame), .ev_tx_babble(ev_tx_babble));

  // memory model and back-pressure source
  logic [31:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  assign mem_req_ready = lfsr[1] | lfsr[4];
  assign out_ready     = lfsr[7] | lfsr[10];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_waddr[9:0]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_waddr[9:0]];
      end
    end
  end

  // stream sink and event counters
  logic [7:0] rx_d [0:1023];
  logic       rx_s [0:1023];
  logic       rx_e [0:1023];
  int rx_n = 0, n_buf = 0, n_frame = 0, n_bab = 0;
  always @(posedge clk) begin
    if (out_valid && out_ready) begin
      rx_d[rx_n[9:0]] <= out_data;
      rx_s[rx_n[9:0]] <= out_sof;
      rx_e[rx_n[9:0]] <= out_eof;
      rx_n <= rx_n + 1;
    end
    if (ev_tx_buf)    n_buf   <= n_buf + 1;
    if (ev_tx_frame)  n_frame <= n_frame + 1;
    if (ev_tx_babble) n_bab   <= n_bab + 1;
  end

  // bookkeeping of checks
  int n_chk = 0, n_fail = 0;

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    report_end();
  end

  function automatic logic [7:0] pat(input int a);
    int v;
    v = a * 13 + (a >> 8) * 7 + 1;
    return v[7:0];
  endfunction

  // expected stream built from the requirements
  logic [7:0] ex_d [0:1023];
  bit         ex_s [0:1023];
  bit         ex_e [0:1023];
  int ex_n = 0, efc = 0, ex_bab = 0, cmp_at = 0;

  task automatic exp_desc(input int ptr, input int len, input bit last);
    int room, take;
    room = MAXF - efc;
    take = (len > room) ? room : len;
    if (len > room) ex_bab++;
    for (int i = 0; i < take; i++) begin
      ex_d[ex_n] = pat(ptr + i);
      ex_s[ex_n] = (efc + i == 0);
      ex_e[ex_n] = 1'b0;
      ex_n++;
    end
    efc += take;
    if (last) begin
      if (efc > 0) ex_e[ex_n-1] = 1'b1;
      efc = 0;
    end
  endtask

  task automatic cmp_stream(input string req);
    int bad;
    bad = -1;
    chk(rx_n == ex_n, req, "stream byte count", rx_n, ex_n);
    for (int k = cmp_at; k < ex_n && k < rx_n; k++)
      if (bad < 0 && (rx_d[k] !== ex_d[k] || rx_s[k] !== ex_s[k] || rx_e[k] !== ex_e[k]))
        bad = k;
    if (bad >= 0)
      chk(1'b0, req, "stream byte {data,sof,eof}",
          {rx_d[bad], 3'b0, rx_s[bad], 3'b0, rx_e[bad]},
          {ex_d[bad], 3'b0, ex_s[bad], 3'b0, ex_e[bad]});
    else
      chk(1'b1, req, "stream content", 0, 0);
    cmp_at = ex_n;
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input int len, input int ptr);
    mem[a >> 2]       <= {fl, len[15:0]};
    mem[(a >> 2) + 1] <= ptr;
  endtask

  task automatic set_base(input int a);
    @(negedge clk);
    base_wr <= 1'b1;
    base_wdata <= a;
    @(negedge clk);
    base_wr <= 1'b0;
  endtask

  task automatic do_kick();
    @(negedge clk);
    kick <= 1'b1;
    @(negedge clk);
    kick <= 1'b0;
  endtask

  task automatic wait_quiet();
    repeat (3) @(posedge clk);
    while (busy || out_valid) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int b0, b1, b2;
    for (int w = 0; w < 1024; w++)
      mem[w] <= {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!busy, "R13", "busy after reset", busy, 0);
    chk(!out_valid, "R13", "out_valid after reset", out_valid, 0);
    chk(!mem_req_valid, "R13", "mem_req_valid after reset", mem_req_valid, 0);
    chk(!(ev_tx_buf | ev_tx_frame | ev_tx_babble), "R13", "events after reset", 1, 0);
    enable <= 1'b1;

    // R1 R6 R8 R9: single-buffer frames over all alignments and short lengths
    for (int off = 0; off < 4; off++) begin
      for (int len = 0; len < 10; len++) begin
        int ptr;
        ptr = 32'h400 + 32 * len + off;
        b0 = n_buf; b1 = n_frame;
        put_desc(32'h40, F_RDY | F_LAST, len, ptr);
        put_desc(32'h48, 16'h0000, 7, 32'h123);
        set_base(32'h40);
        exp_desc(ptr, len, 1'b1);
        do_kick();
        wait_quiet();
        cmp_stream("R6");
        chk(n_buf - b0 == 1, "R9", "buffer events", n_buf - b0, 1);
        chk(n_frame - b1 == 1, "R9", "frame events", n_frame - b1, 1);
        chk(mem[16] == {F_LAST, len[15:0]}, "R8", "written-back word 0", mem[16], {F_LAST, len[15:0]});
        chk(mem[17] == ptr, "R8", "pointer word kept", mem[17], ptr);
        chk(mem[18] == {16'h0000, 16'd7}, "R3", "stopper descriptor untouched", mem[18], 7);
      end
    end

    // R5 R6: chained buffers with empty middle, wrap back to base
    b0 = n_buf; b1 = n_frame;
    put_desc(32'h80, F_RDY, 3, 32'h601);
    put_desc(32'h88, F_RDY, 0, 32'h700);
    put_desc(32'h90, F_RDY | F_WRAP | F_LAST, 6, 32'h703);
    set_base(32'h80);
    exp_desc(32'h601, 3, 0); exp_desc(32'h700, 0, 0); exp_desc(32'h703, 6, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R6");
    chk(n_buf - b0 == 3, "R9", "buffer events chained", n_buf - b0, 3);
    chk(n_frame - b1 == 1, "R9", "frame events chained", n_frame - b1, 1);
    put_desc(32'h80, F_RDY | F_LAST, 2, 32'h650);
    exp_desc(32'h650, 2, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R5");
    chk(mem[32'h80 >> 2][31] == 1'b0, "R5", "wrapped-to descriptor consumed", mem[32'h80 >> 2][31], 0);

    // R7: truncation at the frame limit
    b2 = n_bab;
    put_desc(32'hC0, F_RDY, 30, 32'h800);
    put_desc(32'hC8, F_RDY | F_LAST, 25, 32'h900);
    put_desc(32'hD0, 16'h0000, 0, 0);
    set_base(32'hC0);
    exp_desc(32'h800, 30, 0); exp_desc(32'h900, 25, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R7");
    chk(n_bab - b2 == ex_bab, "R7", "babble events", n_bab - b2, ex_bab);
    chk(mem[32'hC8 >> 2] == {F_LAST, 16'd25}, "R8", "clipped length kept", mem[32'hC8 >> 2], {F_LAST, 16'd25});

    // R3: stop at non-ready, resume on next kick
    put_desc(32'h100, F_RDY | F_LAST, 4, 32'h980);
    put_desc(32'h108, F_LAST, 5, 32'h990);
    set_base(32'h100);
    exp_desc(32'h980, 4, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R3");
    chk(mem[32'h108 >> 2] == {F_LAST, 16'd5}, "R3", "non-ready descriptor untouched", mem[32'h108 >> 2], {F_LAST, 16'd5});
    put_desc(32'h108, F_RDY | F_LAST, 5, 32'h990);
    put_desc(32'h110, 16'h0000, 0, 0);
    exp_desc(32'h990, 5, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R3");

    // R2: kick ignored while disabled
    enable <= 1'b0;
    b0 = n_buf;
    put_desc(32'h140, F_RDY | F_LAST, 3, 32'h9C0);
    put_desc(32'h148, 16'h0000, 0, 0);
    set_base(32'h140);
    do_kick();
    repeat (20) @(negedge clk);
    chk(!busy, "R2", "busy after disabled kick", busy, 0);
    chk(n_buf == b0, "R2", "buffer events after disabled kick", n_buf - b0, 0);
    chk(mem[32'h140 >> 2][31], "R2", "descriptor still ready", mem[32'h140 >> 2][31], 1);
    chk(rx_n == ex_n, "R2", "no stream beats", rx_n, ex_n);
    enable <= 1'b1;
    exp_desc(32'h9C0, 3, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R2");

    // R4: walk cap, then resume with a second kick
    for (int i = 0; i < 8; i++)
      put_desc(32'h180 + 8*i, (i == 7) ? (F_RDY | F_LAST) : F_RDY, 1, 32'hA00 + i);
    put_desc(32'h1C0, 16'h0000, 0, 0);
    for (int i = 0; i < 8; i++) exp_desc(32'hA00 + i, 1, i == 7);
    set_base(32'h180);
    b0 = n_buf;
    do_kick();
    wait_quiet();
    chk(n_buf - b0 == MAXD, "R4", "descriptors in one walk", n_buf - b0, MAXD);
    chk(mem[(32'h180 + 8*MAXD) >> 2][31], "R4", "descriptor past cap still ready", 0, 1);
    do_kick();
    wait_quiet();
    chk(n_buf - b0 == 8, "R4", "descriptors after resume", n_buf - b0, 8);
    cmp_stream("R4");

    // R11: kick during a walk is latched
    for (int i = 0; i < 8; i++)
      put_desc(32'h200 + 8*i, (i == 7) ? (F_RDY | F_LAST) : F_RDY, 1, 32'hA40 + i);
    put_desc(32'h240, 16'h0000, 0, 0);
    for (int i = 0; i < 8; i++) exp_desc(32'hA40 + i, 1, i == 7);
    set_base(32'h200);
    b0 = n_buf; b1 = n_frame;
    do_kick();
    repeat (3) @(negedge clk);
    chk(busy, "R11", "busy during walk", busy, 1);
    do_kick();
    wait_quiet();
    chk(n_buf - b0 == 8, "R11", "descriptors with latched kick", n_buf - b0, 8);
    chk(n_frame - b1 == 1, "R11", "frame events with latched kick", n_frame - b1, 1);
    cmp_stream("R11");

    // R10 R8: base low bits dropped; other flag bits survive write-back
    put_desc(32'h280, 16'h8C5A, 3, 32'hB00);
    put_desc(32'h288, 16'h0000, 0, 0);
    set_base(32'h283);
    exp_desc(32'hB00, 3, 1);
    do_kick();
    wait_quiet();
    cmp_stream("R10");
    chk(mem[32'h280 >> 2] == {16'h0C5A, 16'd3}, "R8", "other flags kept", mem[32'h280 >> 2], {16'h0C5A, 16'd3});

    report_end();
  end
endmodule